// File: doc/BRIEF.md
# Split Virtqueue Descriptor Chain Fetcher

This block is the device-side front end of one split virtqueue. Software programs a single guest page number; from it the block derives where the descriptor table, the available ring and the used ring live, with the used ring pushed out to the next page boundary. It keeps the running next-available index and, when a command arrives, fetches work posted by the driver through a one-outstanding memory read port.

A fetch reads the driver's published available index to decide whether anything is pending, then reads the head descriptor index from the available ring slot, and then follows the descriptor chain through its next links. Each descriptor becomes a segment record (buffer address and length) on an output stream. The record is marked as device-writable ("in") or device-readable ("out") and carries its position within its own direction. A completion pulse reports the head index, the per-direction counts and whether anything was found. A peek does the same walk without consuming the entry; a skip consumes it without reading any descriptors. A chain longer than the queue size is cut off and flagged, which protects the walker against looping chains.

Top module: `vq_chain_fetcher`

## Requirements
- R1: After a nonzero page number P is written, desc_base = P << 12, avail_base = desc_base + 16*QSIZE, and used_base = avail_base + 4 + 2*QSIZE rounded up to the next 4096-byte boundary.
- R2: Writing page number 0 clears desc_base, avail_base, used_base and next_avail.
- R3: Writing a nonzero page number sets next_avail to 0.
- R4: The queue is empty when next_avail equals the 16-bit value read at avail_base+2; a fetch, peek or skip on an empty queue completes with done_found=0, emits no segment and leaves next_avail unchanged.
- R5: cmd_op 2'b00 (fetch) reads the head index at avail_base + 4 + 2*(next_avail mod QSIZE), reports it on done_head and increments next_avail by 1.
- R6: cmd_op 2'b01 (peek) walks and reports exactly like a fetch but leaves next_avail unchanged.
- R7: cmd_op 2'b10 or 2'b11 (skip) on a non-empty queue increments next_avail by 1, emits no segment and issues only the one read of the available index.
- R8: Descriptor i is 16 bytes at desc_base + 16*(i mod QSIZE): 64-bit address at +0, 32-bit length at +8, 16-bit flags at +12, 16-bit next index at +14; the walk moves to the next index while flag bit 0 is set.
- R9: A descriptor with flag bit 1 set is emitted with seg_is_in=1, otherwise with seg_is_in=0; seg_pos counts from 0 separately per direction, and done_n_in/done_n_out give the totals of the current command.
- R10: If flag bit 0 is still set on the QSIZE-th segment, the walk stops with done_err=1 and done_found=1 after exactly QSIZE segments.
- R11: After reset all ring bases and next_avail are 0, no request, segment or completion is active and cmd_ready is 1.
- R12: At most one memory read is outstanding; rd_req is a one-cycle pulse and the next one follows only after rd_rsp_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Page number write strobe (taken while idle) |
| cfg_pfn | input | 32 | Page number of the ring area; 0 resets the queue |
| cmd_valid | input | 1 | Command strobe, accepted while cmd_ready is 1 |
| cmd_op | input | 2 | 00 fetch, 01 peek, 1x skip |
| cmd_ready | output | 1 | Block idle and able to accept a command |
| rd_req | output | 1 | Memory read request pulse |
| rd_addr | output | ADDR_W | Byte address of the 8-byte read |
| rd_rsp_valid | input | 1 | Read response strobe |
| rd_rsp_data | input | 64 | Little-endian 8 bytes from rd_addr |
| seg_valid | output | 1 | Segment record strobe |
| seg_addr | output | 64 | Segment buffer address |
| seg_len | output | 32 | Segment length in bytes |
| seg_is_in | output | 1 | 1 device-writable, 0 device-readable |
| seg_pos | output | CNT_W | Position within its direction |
| done | output | 1 | Command completion pulse |
| done_found | output | 1 | An entry was present |
| done_err | output | 1 | Chain cut off at QSIZE segments |
| done_head | output | 16 | Head descriptor index |
| done_n_in | output | CNT_W | Count of "in" segments |
| done_n_out | output | CNT_W | Count of "out" segments |
| desc_base | output | ADDR_W | Descriptor table base |
| avail_base | output | ADDR_W | Available ring base |
| used_base | output | ADDR_W | Used ring base |
| next_avail | output | 16 | Next-available index |

## Verification
The walk is driven with a single readable descriptor, a three-descriptor chain that switches from readable to writable part-way, and a self-linked descriptor; these separate the per-direction position counters, the next-link following and the chain-length guard. Head indices and available slots above QSIZE show whether both tables wrap their index modulo the queue size. Empty-queue commands, a peek followed by a fetch of the same entry, and skips (with the read requests counted at the port) separate the three commands' effect on next_avail and on memory traffic. Page number writes of a nonzero value and of zero check the derived layout, the page rounding of the used ring and the clearing of the queue state.

// File: rtl/vq_pkg.sv
package vq_pkg;
   typedef enum logic [3:0] {
      ST_IDLE, ST_AIDX_REQ, ST_AIDX_WAIT, ST_HEAD_REQ, ST_HEAD_WAIT,
      ST_DLO_REQ, ST_DLO_WAIT, ST_DHI_REQ, ST_DHI_WAIT, ST_DONE
   } walk_state_t;

   localparam logic [1:0] OP_FETCH = 2'b00;
   localparam logic [1:0] OP_PEEK  = 2'b01;

   localparam int FLAG_CHAIN_BIT = 0;
   localparam int FLAG_DEVWR_BIT = 1;

   typedef struct packed {
      logic [63:0] buf_addr;
      logic [31:0] buf_len;
      logic        chained;
      logic        dev_writes;
      logic [15:0] link;
   } desc_rec_t;
endpackage

// File: rtl/vq_ring_regs.sv
module vq_ring_regs #(
   parameter int ADDR_W     = 64,
   parameter int PAGE_SHIFT = 12,
   parameter int QSIZE      = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [31:0]       wr_pfn,
   input  logic              adv,
   output logic [ADDR_W-1:0] desc_base,
   output logic [ADDR_W-1:0] avail_base,
   output logic [ADDR_W-1:0] used_base,
   output logic [15:0]       next_avail
);
   localparam longint PAGE_BYTES = longint'(1) << PAGE_SHIFT;
   localparam longint TBL_BYTES  = 16 * longint'(QSIZE);
   localparam longint AVAIL_END  = TBL_BYTES + 4 + 2 * longint'(QSIZE);
   localparam longint USED_OFF   = ((AVAIL_END + PAGE_BYTES - 1) / PAGE_BYTES) * PAGE_BYTES;

   generate
      if (PAGE_SHIFT + 32 > ADDR_W) begin : g_bad_width
         $error("vq_ring_regs: ADDR_W too narrow for shifted page number");
      end
   endgenerate

   logic [ADDR_W-1:0] new_desc;
   assign new_desc = ADDR_W'(wr_pfn) << PAGE_SHIFT;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         desc_base  <= '0;
         avail_base <= '0;
         used_base  <= '0;
         next_avail <= '0;
      end else if (wr_en) begin
         next_avail <= '0;
         if (wr_pfn == '0) begin
            desc_base  <= '0;
            avail_base <= '0;
            used_base  <= '0;
         end else begin
            desc_base  <= new_desc;
            avail_base <= new_desc + ADDR_W'(TBL_BYTES);
            used_base  <= new_desc + ADDR_W'(USED_OFF);
         end
      end else if (adv) begin
         next_avail <= next_avail + 16'd1;
      end
   end

   // R1: used ring sits on a page boundary past the end of the available ring
   a_r1_used_page: assert property (@(posedge clk) disable iff (!rst_n)
      (desc_base != '0) |-> (used_base[PAGE_SHIFT-1:0] == '0 &&
                             used_base >= avail_base + ADDR_W'(4 + 2 * QSIZE)));

   // R5/R7: the index only moves by one step or by a page number write
   a_r5_step_only: assert property (@(posedge clk) disable iff (!rst_n)
      (next_avail != $past(next_avail)) |->
         ($past(wr_en) || next_avail == $past(next_avail) + 16'd1));
endmodule

// File: rtl/vq_desc_unpack.sv
module vq_desc_unpack
   import vq_pkg::*;
(
   input  logic [63:0] word_lo,
   input  logic [63:0] word_hi,
   output desc_rec_t   rec
);
   logic [15:0] flags;
   assign flags = word_hi[47:32];

   always_comb begin
      rec.buf_addr   = word_lo;
      rec.buf_len    = word_hi[31:0];
      rec.chained    = flags[FLAG_CHAIN_BIT];
      rec.dev_writes = flags[FLAG_DEVWR_BIT];
      rec.link       = word_hi[63:48];
   end

   logic unused_flags;
   assign unused_flags = ^{flags[15:2]};
endmodule

// File: rtl/vq_seg_tally.sv
module vq_seg_tally #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             bump,
   input  logic             bump_in,
   output logic [CNT_W-1:0] n_in,
   output logic [CNT_W-1:0] n_out,
   output logic [CNT_W-1:0] total
);
   assign total = n_in + n_out;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         n_in  <= '0;
         n_out <= '0;
      end else if (clear) begin
         n_in  <= '0;
         n_out <= '0;
      end else if (bump) begin
         if (bump_in) n_in  <= n_in + CNT_W'(1);
         else         n_out <= n_out + CNT_W'(1);
      end
   end

   // R9: each emitted segment lands in exactly one direction count
   a_r9_one_side: assert property (@(posedge clk) disable iff (!rst_n)
      (bump && !clear) |=> (n_in + n_out) == $past(n_in + n_out) + CNT_W'(1));
endmodule

// File: rtl/vq_chain_fetcher.sv
module vq_chain_fetcher
   import vq_pkg::*;
#(
   parameter int ADDR_W     = 64,
   parameter int PAGE_SHIFT = 12,
   parameter int QSIZE      = 16,
   localparam int CNT_W     = $clog2(QSIZE + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [31:0]       cfg_pfn,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_op,
   output logic              cmd_ready,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_rsp_valid,
   input  logic [63:0]       rd_rsp_data,
   output logic              seg_valid,
   output logic [63:0]       seg_addr,
   output logic [31:0]       seg_len,
   output logic              seg_is_in,
   output logic [CNT_W-1:0]  seg_pos,
   output logic              done,
   output logic              done_found,
   output logic              done_err,
   output logic [15:0]       done_head,
   output logic [CNT_W-1:0]  done_n_in,
   output logic [CNT_W-1:0]  done_n_out,
   output logic [ADDR_W-1:0] desc_base,
   output logic [ADDR_W-1:0] avail_base,
   output logic [ADDR_W-1:0] used_base,
   output logic [15:0]       next_avail
);
   localparam int SLOT_W  = (QSIZE > 1) ? $clog2(QSIZE) : 1;
   localparam bit IS_POW2 = (QSIZE & (QSIZE - 1)) == 0;

   generate
      if (QSIZE < 2 || QSIZE > 32768) begin : g_bad_qsize
         $error("vq_chain_fetcher: QSIZE out of range");
      end
      if (ADDR_W < 48) begin : g_bad_addr
         $error("vq_chain_fetcher: ADDR_W below 48");
      end
   endgenerate

   walk_state_t state;
   logic [1:0]  op_q;
   logic [15:0] cur_idx;
   logic [63:0] lo_q;
   logic        adv;
   logic        idle;
   logic        accept;

   assign idle      = (state == ST_IDLE);
   assign cmd_ready = idle;
   assign accept    = idle && cmd_valid;
   assign done      = (state == ST_DONE);

   vq_ring_regs #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .QSIZE(QSIZE)) u_ring (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr && idle), .wr_pfn(cfg_pfn), .adv(adv),
      .desc_base(desc_base), .avail_base(avail_base), .used_base(used_base),
      .next_avail(next_avail)
   );

   // slot selection: mask for power-of-two sizes, remainder otherwise
   logic [SLOT_W-1:0] avail_slot, desc_slot;
   generate
      if (IS_POW2) begin : g_slot_mask
         assign avail_slot = next_avail[SLOT_W-1:0];
         assign desc_slot  = cur_idx[SLOT_W-1:0];
      end else begin : g_slot_mod
         logic [15:0] a_mod, d_mod;
         assign a_mod      = next_avail % 16'(QSIZE);
         assign d_mod      = cur_idx % 16'(QSIZE);
         assign avail_slot = a_mod[SLOT_W-1:0];
         assign desc_slot  = d_mod[SLOT_W-1:0];
      end
   endgenerate

   logic [ADDR_W-1:0] desc_addr;
   assign desc_addr = desc_base + (ADDR_W'(desc_slot) << 4);

   always_comb begin
      rd_req  = 1'b0;
      rd_addr = '0;
      unique case (state)
         ST_AIDX_REQ: begin rd_req = 1'b1; rd_addr = avail_base + ADDR_W'(2); end
         ST_HEAD_REQ: begin rd_req = 1'b1; rd_addr = avail_base + ADDR_W'(4) + (ADDR_W'(avail_slot) << 1); end
         ST_DLO_REQ:  begin rd_req = 1'b1; rd_addr = desc_addr; end
         ST_DHI_REQ:  begin rd_req = 1'b1; rd_addr = desc_addr + ADDR_W'(8); end
         default: ;
      endcase
   end

   desc_rec_t rec;
   vq_desc_unpack u_unpack (.word_lo(lo_q), .word_hi(rd_rsp_data), .rec(rec));

   logic             emit;
   logic [CNT_W-1:0] n_in, n_out, total;
   assign emit = (state == ST_DHI_WAIT) && rd_rsp_valid;

   vq_seg_tally #(.CNT_W(CNT_W)) u_tally (
      .clk(clk), .rst_n(rst_n), .clear(accept), .bump(emit), .bump_in(rec.dev_writes),
      .n_in(n_in), .n_out(n_out), .total(total)
   );
   assign done_n_in  = n_in;
   assign done_n_out = n_out;

   logic last_allowed;
   assign last_allowed = (total + CNT_W'(1)) >= CNT_W'(QSIZE);

   always_comb begin
      adv = 1'b0;
      if (rd_rsp_valid) begin
         if (state == ST_AIDX_WAIT && rd_rsp_data[15:0] != next_avail && op_q[1]) adv = 1'b1;
         if (state == ST_HEAD_WAIT && op_q == OP_FETCH) adv = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         op_q       <= '0;
         cur_idx    <= '0;
         lo_q       <= '0;
         seg_valid  <= 1'b0;
         seg_addr   <= '0;
         seg_len    <= '0;
         seg_is_in  <= 1'b0;
         seg_pos    <= '0;
         done_found <= 1'b0;
         done_err   <= 1'b0;
         done_head  <= '0;
      end else begin
         seg_valid <= 1'b0;
         unique case (state)
            ST_IDLE: if (cmd_valid) begin
               op_q       <= cmd_op;
               done_found <= 1'b0;
               done_err   <= 1'b0;
               done_head  <= '0;
               state      <= ST_AIDX_REQ;
            end
            ST_AIDX_REQ: state <= ST_AIDX_WAIT;
            ST_AIDX_WAIT: if (rd_rsp_valid) begin
               if (rd_rsp_data[15:0] == next_avail) begin
                  state <= ST_DONE;
               end else if (op_q[1]) begin
                  done_found <= 1'b1;
                  state      <= ST_DONE;
               end else begin
                  state <= ST_HEAD_REQ;
               end
            end
            ST_HEAD_REQ: state <= ST_HEAD_WAIT;
            ST_HEAD_WAIT: if (rd_rsp_valid) begin
               cur_idx    <= rd_rsp_data[15:0];
               done_head  <= rd_rsp_data[15:0];
               done_found <= 1'b1;
               state      <= ST_DLO_REQ;
            end
            ST_DLO_REQ: state <= ST_DLO_WAIT;
            ST_DLO_WAIT: if (rd_rsp_valid) begin
               lo_q  <= rd_rsp_data;
               state <= ST_DHI_REQ;
            end
            ST_DHI_REQ: state <= ST_DHI_WAIT;
            ST_DHI_WAIT: if (rd_rsp_valid) begin
               seg_valid <= 1'b1;
               seg_addr  <= rec.buf_addr;
               seg_len   <= rec.buf_len;
               seg_is_in <= rec.dev_writes;
               seg_pos   <= rec.dev_writes ? n_in : n_out;
               if (!rec.chained) begin
                  state <= ST_DONE;
               end else if (last_allowed) begin
                  done_err <= 1'b1;
                  state    <= ST_DONE;
               end else begin
                  cur_idx <= rec.link;
                  state   <= ST_DLO_REQ;
               end
            end
            ST_DONE: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R12: a request never repeats in the following cycle
   a_r12_single_req: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> !rd_req);

   // R12: no request while the block is idle or completing
   a_r12_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> !cmd_ready && !done);

   // R4: an empty result carries no segments
   a_r4_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !done_found) |-> (done_n_in == '0 && done_n_out == '0 && !done_err));

   // R10: a cut-off chain has exactly QSIZE segments
   a_r10_err_full: assert property (@(posedge clk) disable iff (!rst_n)
      (done && done_err) |-> (32'(done_n_in) + 32'(done_n_out) == 32'(QSIZE)));

   // R10: segment count never passes the queue size
   a_r10_cap: assert property (@(posedge clk) disable iff (!rst_n)
      seg_valid |-> (32'(seg_pos) < 32'(QSIZE)));

   // R6: a peek leaves the index where it was
   a_r6_peek_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!idle && op_q == OP_PEEK) |=> $stable(next_avail));
endmodule

// File: tb/vq_chain_fetcher_tb.sv
module vq_chain_fetcher_tb;
   localparam int QSIZE = 16;
   localparam int CNT_W = $clog2(QSIZE + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic              cfg_wr = 1'b0;
   logic [31:0]       cfg_pfn = '0;
   logic              cmd_valid = 1'b0;
   logic [1:0]        cmd_op = '0;
   logic              cmd_ready;
   logic              rd_req;
   logic [63:0]       rd_addr;
   logic              rd_rsp_valid;
   logic [63:0]       rd_rsp_data;
   logic              seg_valid;
   logic [63:0]       seg_addr;
   logic [31:0]       seg_len;
   logic              seg_is_in;
   logic [CNT_W-1:0]  seg_pos;
   logic              done, done_found, done_err;
   logic [15:0]       done_head;
   logic [CNT_W-1:0]  done_n_in, done_n_out;
   logic [63:0]       desc_base, avail_base, used_base;
   logic [15:0]       next_avail;

   vq_chain_fetcher #(.QSIZE(QSIZE)) u_dut (.*);

   int total = 0;
   int bad = 0;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // sparse byte memory with two-cycle read latency
   logic [7:0] mem [logic [63:0]];
   logic [63:0] pend_addr;
   int          lat;

   function automatic logic [63:0] rd64(input logic [63:0] a);
      logic [63:0] v = '0;
      for (int i = 0; i < 8; i++)
         v[8*i +: 8] = mem.exists(a + 64'(i)) ? mem[a + 64'(i)] : 8'h00;
      return v;
   endfunction

   task automatic put(input logic [63:0] a, input logic [63:0] v, input int nbytes);
      for (int i = 0; i < nbytes; i++) mem[a + 64'(i)] = v[8*i +: 8];
   endtask

   localparam logic [63:0] DESC = 64'h5000;
   localparam logic [63:0] AVL  = 64'h5100;

   task automatic set_desc(input int idx, input logic [63:0] a, input logic [31:0] l,
                           input logic [15:0] fl, input logic [15:0] nx);
      put(DESC + 64'(16 * idx), a, 8);
      put(DESC + 64'(16 * idx) + 8, {16'(nx), fl, l}, 8);
   endtask

   always @(posedge clk) begin
      rd_rsp_valid <= 1'b0;
      if (!rst_n) begin
         lat <= 0;
         rd_rsp_data <= '0;
      end else if (rd_req) begin
         pend_addr <= rd_addr;
         lat <= 2;
      end else if (lat != 0) begin
         lat <= lat - 1;
         if (lat == 1) begin
            rd_rsp_valid <= 1'b1;
            rd_rsp_data  <= rd64(pend_addr);
         end
      end
   end

   // port monitor
   logic [63:0]      lg_addr [0:31];
   logic [31:0]      lg_len  [0:31];
   logic             lg_in   [0:31];
   logic [CNT_W-1:0] lg_pos  [0:31];
   int n_seg = 0, rd_cnt = 0, overlap = 0;
   bit got_done = 0, outstanding = 0;
   logic g_found, g_err;
   logic [15:0] g_head;
   logic [CNT_W-1:0] g_in, g_out;

   always @(negedge clk) begin
      if (rd_rsp_valid) outstanding = 0;
      if (rd_req) begin
         if (outstanding) overlap++;
         outstanding = 1;
         rd_cnt++;
      end
      if (seg_valid && n_seg < 32) begin
         lg_addr[n_seg] = seg_addr; lg_len[n_seg] = seg_len;
         lg_in[n_seg] = seg_is_in; lg_pos[n_seg] = seg_pos;
         n_seg++;
      end
      if (done) begin
         got_done = 1; g_found = done_found; g_err = done_err; g_head = done_head;
         g_in = done_n_in; g_out = done_n_out;
      end
   end

   task automatic run_cmd(input logic [1:0] op);
      @(negedge clk);
      n_seg = 0; rd_cnt = 0; got_done = 0;
      cmd_valid = 1'b1; cmd_op = op;
      @(negedge clk);
      cmd_valid = 1'b0;
      for (int i = 0; i < 3000 && !got_done; i++) @(negedge clk);
      if (!got_done) chk("cmd completion", 0, 1);
   endtask

   task automatic write_pfn(input logic [31:0] p);
      @(negedge clk); cfg_wr = 1'b1; cfg_pfn = p;
      @(negedge clk); cfg_wr = 1'b0;
   endtask

   task automatic t_reset_state;
      chk("R11 desc_base", desc_base, 0);
      chk("R11 avail_base", avail_base, 0);
      chk("R11 used_base", used_base, 0);
      chk("R11 next_avail", 64'(next_avail), 0);
      chk("R11 cmd_ready", 64'(cmd_ready), 1);
      chk("R11 idle outputs", 64'({rd_req, seg_valid, done}), 0);
   endtask

   task automatic t_layout;
      write_pfn(32'h5);
      chk("R1 desc_base", desc_base, 64'h5000);
      chk("R1 avail_base", avail_base, 64'h5100);
      chk("R1 used_base", used_base, 64'h6000);
      chk("R3 next_avail after init", 64'(next_avail), 0);
   endtask

   task automatic t_empty;
      put(AVL + 2, 0, 2);
      for (int op = 0; op < 3; op++) begin
         run_cmd(2'(op));
         chk("R4 empty found", 64'(g_found), 0);
         chk("R4 empty segments", 64'(n_seg), 0);
         chk("R4 empty next_avail", 64'(next_avail), 0);
      end
   endtask

   task automatic t_single;
      put(AVL + 2, 1, 2);
      put(AVL + 4, 3, 2);
      set_desc(3, 64'hAAAA_0000_1000, 32'h200, 16'h0, 16'h0);
      run_cmd(2'b00);
      chk("R5 head", 64'(g_head), 3);
      chk("R5 next_avail", 64'(next_avail), 1);
      chk("R8 one segment", 64'(n_seg), 1);
      chk("R8 seg addr", lg_addr[0], 64'hAAAA_0000_1000);
      chk("R8 seg len", 64'(lg_len[0]), 64'h200);
      chk("R9 out dir", 64'(lg_in[0]), 0);
      chk("R9 counts", 64'({g_in, g_out}), 64'({CNT_W'(0), CNT_W'(1)}));
   endtask

   task automatic check_chain(input string tag);
      chk({tag, " head"}, 64'(g_head), 7);
      chk({tag, " R8 seg count"}, 64'(n_seg), 3);
      chk({tag, " R8 seg0 addr"}, lg_addr[0], 64'h1000_0000);
      chk({tag, " R8 seg1 len"}, 64'(lg_len[1]), 64'h80);
      chk({tag, " R8 seg2 addr"}, lg_addr[2], 64'h3000);
      chk({tag, " R9 dirs"}, 64'({lg_in[0], lg_in[1], lg_in[2]}), 64'b011);
      chk({tag, " R9 pos"}, 64'({lg_pos[0], lg_pos[1], lg_pos[2]}),
          64'({CNT_W'(0), CNT_W'(0), CNT_W'(1)}));
      chk({tag, " R9 n_in"}, 64'(g_in), 2);
      chk({tag, " R9 n_out"}, 64'(g_out), 1);
   endtask

   task automatic t_chain_peek_fetch;
      put(AVL + 2, 2, 2);
      put(AVL + 6, 7, 2);
      set_desc(7, 64'h1000_0000, 32'h40, 16'h1, 16'd2);
      set_desc(2, 64'h2000, 32'h80, 16'h3, 16'd9);
      set_desc(9, 64'h3000, 32'h100, 16'h2, 16'd0);
      run_cmd(2'b01);
      check_chain("R6 peek");
      chk("R6 peek keeps next_avail", 64'(next_avail), 1);
      run_cmd(2'b00);
      check_chain("R5 fetch");
      chk("R5 fetch next_avail", 64'(next_avail), 2);
   endtask

   task automatic t_skip;
      put(AVL + 2, 3, 2);
      run_cmd(2'b10);
      chk("R7 skip found", 64'(g_found), 1);
      chk("R7 skip next_avail", 64'(next_avail), 3);
      chk("R7 skip no segments", 64'(n_seg), 0);
      chk("R7 skip one read", 64'(rd_cnt), 1);
   endtask

   task automatic t_wrap;
      put(AVL + 2, 20, 2);
      for (int k = 0; k < 14; k++) run_cmd(2'b11);
      chk("R7 skips reach 17", 64'(next_avail), 17);
      put(AVL + 6, 20, 2);
      set_desc(4, 64'h4444, 32'h10, 16'h2, 16'h0);
      run_cmd(2'b00);
      chk("R5 wrapped slot head", 64'(g_head), 20);
      chk("R8 wrapped desc addr", lg_addr[0], 64'h4444);
      chk("R9 wrapped in dir", 64'(lg_in[0]), 1);
      chk("R5 next_avail 18", 64'(next_avail), 18);
   endtask

   task automatic t_loop_guard;
      put(AVL + 2, 19, 2);
      put(AVL + 8, 11, 2);
      set_desc(11, 64'hB0, 32'h8, 16'h1, 16'd11);
      run_cmd(2'b00);
      chk("R10 err flag", 64'(g_err), 1);
      chk("R10 found", 64'(g_found), 1);
      chk("R10 segment count", 64'(n_seg), QSIZE);
      chk("R10 n_out", 64'(g_out), QSIZE);
      chk("R10 last pos", 64'(lg_pos[QSIZE-1]), QSIZE - 1);
      run_cmd(2'b00);
      chk("R4 empty at 19", 64'(g_found), 0);
      chk("R4 next_avail kept", 64'(next_avail), 19);
   endtask

   task automatic t_clear;
      write_pfn(32'h0);
      chk("R2 desc_base", desc_base, 0);
      chk("R2 avail_base", avail_base, 0);
      chk("R2 used_base", used_base, 0);
      chk("R2 next_avail", 64'(next_avail), 0);
      write_pfn(32'h7);
      chk("R1 desc_base pfn7", desc_base, 64'h7000);
      chk("R1 used_base pfn7", used_base, 64'h8000);
      chk("R3 next_avail zero", 64'(next_avail), 0);
   endtask

   int cycles = 0;
   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset_state();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_state();
      t_layout();
      t_empty();
      t_single();
      t_chain_peek_fetch();
      t_skip();
      t_wrap();
      t_loop_guard();
      t_clear();
      chk("R12 overlapping reads", 64'(overlap), 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule